// File: doc/BRIEF.md
# Register Status Table with Reorder-Buffer Tag Renaming

This block keeps one entry per architectural register. Each entry holds a ready flag, the last value written to it, and a reorder-buffer tag. When a register is ready, a source lookup returns its value directly. When it is not ready, the lookup returns the tag of the reorder-buffer slot that will produce the value. The consumer then uses that tag to read or wait on the reorder buffer. Operand lookup is an indexed read, not an associative search of the reorder buffer.

Decode renames a destination by writing a freshly allocated tag into the entry. This drops any older pending tag, so output and anti dependencies never stall. Commit writes the final value back into the entry. The entry becomes ready again only if no younger rename has replaced the tag. A flush returns every entry to the ready state. Register 0 is hard-wired to a ready zero.

Each cycle the table serves two source lookups, one rename and one commit. Lookups are combinational and see the state before that cycle's updates.

Top module: `rename_status_table`

## Requirements
- R1: After reset, every register reads as ready with value zero and tag zero.
- R2: A lookup of a ready register returns ready=1, the stored value and tag 0. A lookup of a not-ready register returns ready=0, value 0 and the pending tag.
- R3: A rename of a nonzero register clears its ready flag and stores the new tag, replacing any tag still pending.
- R4: A commit whose tag equals the register's pending tag stores the value and sets the register ready.
- R5: A commit whose tag differs from the register's pending tag stores the value but leaves the register not ready with the newer tag. The stored value becomes visible after a later flush.
- R6: When a rename and a commit hit the same register in one cycle, the register ends not ready with the rename's tag. The commit value is still stored.
- R7: A flush makes every register ready and clears all tags to zero. Stored values are kept.
- R8: A lookup in the same cycle as a rename or commit of the same register returns the state from before that cycle.
- R9: Register 0 always reads ready with value zero. Renames and commits addressed to it have no effect.
- R10: In a cycle with flush asserted, any rename and any commit in that cycle are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all pending tags |
| rd_a_idx | input | 5 | Source lookup A register index |
| rd_a_ready | output | 1 | Lookup A register ready |
| rd_a_value | output | 32 | Lookup A value (zero if not ready) |
| rd_a_tag | output | 6 | Lookup A pending tag (zero if ready) |
| rd_b_idx | input | 5 | Source lookup B register index |
| rd_b_ready | output | 1 | Lookup B register ready |
| rd_b_value | output | 32 | Lookup B value (zero if not ready) |
| rd_b_tag | output | 6 | Lookup B pending tag (zero if ready) |
| ren_en | input | 1 | Rename request |
| ren_reg | input | 5 | Destination register to rename |
| ren_tag | input | 6 | Newly allocated reorder-buffer tag |
| cmt_en | input | 1 | Commit request |
| cmt_reg | input | 5 | Committing destination register |
| cmt_tag | input | 6 | Tag of the committing instruction |
| cmt_value | input | 32 | Committed result |

## Verification
Assertions check the following on every cycle:
- the state a rename leaves behind;
- the ready transition of a matching commit;
- the retention of a newer tag when a commit is stale;
- the rename-over-commit priority;
- the effect of flush on all entries;
- the constant zero read of register 0.

Only the bench's scenarios can show the rest. These are the pre-update view of a lookup in the same cycle as a write, the value written silently by a stale commit and exposed by a later flush, and the dropping of writes in a flush cycle. The bench also shows end-to-end sequences where several renames of one register overlap before their commits arrive.

// File: rtl/rename_status_table.sv
module rename_status_table #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int TW   = 6,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] rd_a_idx,
  output logic          rd_a_ready,
  output logic [DW-1:0] rd_a_value,
  output logic [TW-1:0] rd_a_tag,
  input  logic [AW-1:0] rd_b_idx,
  output logic          rd_b_ready,
  output logic [DW-1:0] rd_b_value,
  output logic [TW-1:0] rd_b_tag,
  input  logic          ren_en,
  input  logic [AW-1:0] ren_reg,
  input  logic [TW-1:0] ren_tag,
  input  logic          cmt_en,
  input  logic [AW-1:0] cmt_reg,
  input  logic [TW-1:0] cmt_tag,
  input  logic [DW-1:0] cmt_value
);

  logic [NREG-1:0] valid_q;
  logic [TW-1:0]   tag_q [NREG];
  logic [DW-1:0]   val_q [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        valid_q[i] <= 1'b1;
        tag_q[i]   <= '0;
        val_q[i]   <= '0;
      end
    end else if (flush) begin
      for (int i = 0; i < NREG; i++) begin
        valid_q[i] <= 1'b1;
        tag_q[i]   <= '0;
      end
    end else begin
      for (int i = 1; i < NREG; i++) begin
        if (cmt_en && cmt_reg == AW'(i))
          val_q[i] <= cmt_value;
        if (ren_en && ren_reg == AW'(i)) begin
          valid_q[i] <= 1'b0;
          tag_q[i]   <= ren_tag;
        end else if (cmt_en && cmt_reg == AW'(i) && tag_q[i] == cmt_tag) begin
          valid_q[i] <= 1'b1;
        end
      end
    end
  end

  assign rd_a_ready = valid_q[rd_a_idx];
  assign rd_a_value = rd_a_ready ? val_q[rd_a_idx] : '0;
  assign rd_a_tag   = rd_a_ready ? '0 : tag_q[rd_a_idx];
  assign rd_b_ready = valid_q[rd_b_idx];
  assign rd_b_value = rd_b_ready ? val_q[rd_b_idx] : '0;
  assign rd_b_tag   = rd_b_ready ? '0 : tag_q[rd_b_idx];

  // R3
  rename_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_en && !flush && ren_reg != '0) |=>
      (!valid_q[$past(ren_reg)] && tag_q[$past(ren_reg)] == $past(ren_tag)));

  // R4
  commit_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_en && !flush && cmt_reg != '0 && !valid_q[cmt_reg] &&
     tag_q[cmt_reg] == cmt_tag && !(ren_en && ren_reg == cmt_reg)) |=>
      (valid_q[$past(cmt_reg)] && val_q[$past(cmt_reg)] == $past(cmt_value)));

  // R5
  stale_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_en && !flush && cmt_reg != '0 && !valid_q[cmt_reg] &&
     tag_q[cmt_reg] != cmt_tag && !(ren_en && ren_reg == cmt_reg)) |=>
      (!valid_q[$past(cmt_reg)] && tag_q[$past(cmt_reg)] == $past(tag_q[cmt_reg])));

  // R6
  rename_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_en && cmt_en && !flush && ren_reg == cmt_reg && ren_reg != '0) |=>
      (!valid_q[$past(ren_reg)] && val_q[$past(ren_reg)] == $past(cmt_value)));

  // R7
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (&valid_q));

  // R9
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == '0) |-> (rd_a_ready && rd_a_value == '0));

endmodule

// File: tb/sim_rename_status_table.sv
module sim_rename_status_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0;
  logic        rd_a_ready, rd_b_ready;
  logic [31:0] rd_a_value, rd_b_value;
  logic [5:0]  rd_a_tag, rd_b_tag;
  logic        ren_en = 1'b0, cmt_en = 1'b0;
  logic [4:0]  ren_reg = '0, cmt_reg = '0;
  logic [5:0]  ren_tag = '0, cmt_tag = '0;
  logic [31:0] cmt_value = '0;

  always #10 clk = ~clk;

  rename_status_table u0 (.*);

  typedef struct {
    bit          port;
    bit          rdy;
    logic [31:0] val;
    logic [5:0]  tg;
    string       req;
  } item_t;

  item_t q[$];
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  bit          m_v [32];
  logic [5:0]  m_t [32];
  logic [31:0] m_val [32];

  function automatic item_t expect_read(bit p, int idx, string req);
    item_t it;
    it.port = p; it.req = req; it.rdy = m_v[idx];
    it.val = m_v[idx] ? m_val[idx] : 32'h0;
    it.tg  = m_v[idx] ? 6'h0 : m_t[idx];
    return it;
  endfunction

  task automatic step(int ra, int rb, bit re, int rr, int rt,
                      bit ce, int cr, int ct, int cv, bit fl, string req);
    @(negedge clk);
    rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
    ren_en = re; ren_reg = 5'(rr); ren_tag = 6'(rt);
    cmt_en = ce; cmt_reg = 5'(cr); cmt_tag = 6'(ct); cmt_value = 32'(cv);
    flush = fl;
    q.push_back(expect_read(0, ra, req));
    q.push_back(expect_read(1, rb, req));
    if (fl) begin
      for (int i = 0; i < 32; i++) begin m_v[i] = 1; m_t[i] = 0; end
    end else begin
      if (ce && cr != 0) begin
        m_val[cr] = 32'(cv);
        if (!(re && rr == cr) && m_t[cr] == 6'(ct)) m_v[cr] = 1;
      end
      if (re && rr != 0) begin m_v[rr] = 0; m_t[rr] = 6'(rt); end
    end
  endtask

  initial begin
    forever begin
      @(negedge clk); #5;
      while (q.size() > 0) begin
        item_t e;
        bit r; logic [31:0] v; logic [5:0] t;
        e = q.pop_front();
        r = e.port ? rd_b_ready : rd_a_ready;
        v = e.port ? rd_b_value : rd_a_value;
        t = e.port ? rd_b_tag : rd_a_tag;
        n_checks++;
        if (r !== e.rdy || v !== e.val || t !== e.tg) begin
          n_fail++;
          $display("FAIL %s port%0d: got rdy=%0b val=%h tag=%0d, exp rdy=%0b val=%h tag=%0d",
                   e.req, e.port, r, v, t, e.rdy, e.val, e.tg);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_v[i] = 1; m_t[i] = 0; m_val[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(5, 0, 0,0,0, 0,0,0,0, 0, "R1 reset");
    step(3, 31, 0,0,0, 0,0,0,0, 0, "R1 reset");
    step(3, 3, 1,3,7, 0,0,0,0, 0, "R8 read during rename");
    step(3, 2, 0,0,0, 0,0,0,0, 0, "R2/R3 pending tag");
    step(3, 3, 0,0,0, 1,3,7,'h55, 0, "R8 read during commit");
    step(3, 3, 0,0,0, 0,0,0,0, 0, "R4 matching commit");
    step(4, 3, 1,4,1, 0,0,0,0, 0, "R3 rename");
    step(4, 0, 1,4,2, 0,0,0,0, 0, "R3 second rename");
    step(4, 0, 0,0,0, 1,4,1,'hAA, 0, "R3 overwrite");
    step(4, 4, 0,0,0, 0,0,0,0, 0, "R5 stale commit");
    step(6, 0, 1,6,3, 0,0,0,0, 0, "R3 rename r6");
    step(6, 4, 1,6,9, 1,6,3,'h11, 0, "R6 setup");
    step(6, 4, 0,0,0, 0,0,0,0, 0, "R6 rename wins");
    step(0, 0, 1,0,4, 0,0,0,0, 0, "R9 rename r0");
    step(0, 0, 0,0,0, 1,0,0,'hFF, 0, "R9 after rename r0");
    step(0, 0, 0,0,0, 0,0,0,0, 0, "R9 after commit r0");
    step(4, 6, 1,7,5, 1,3,0,'h99, 1, "R7 before flush");
    step(4, 6, 0,0,0, 0,0,0,0, 0, "R7 flush keeps values");
    step(7, 3, 0,0,0, 0,0,0,0, 0, "R10 flush drops writes");
    step(8, 9, 1,8,12, 0,0,0,0, 0, "R2 ready read");
    step(8, 9, 1,9,13, 0,0,0,0, 0, "R2 not ready read");
    step(8, 9, 0,0,0, 1,9,13,'h1234, 0, "R4 commit r9");
    step(8, 9, 0,0,0, 1,8,12,'hBEEF, 0, "R4 commit r8");
    step(8, 9, 0,0,0, 0,0,0,0, 0, "R4 both committed");
    @(negedge clk); @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule